// File: doc/BRIEF.md
# Tiny 8-bit Instruction Processor

A minimal processor built around four 8-bit general registers, a 4-bit program counter and a 16-entry internal instruction memory. The testbench or a host loads the memory through a dedicated write port. Each instruction takes two clock cycles. In the first cycle the word at the program counter is captured into an instruction register. In the second cycle that word is decoded and executed. Arithmetic and logic results go to the destination register. Zero and carry flags steer conditional branches.

A manually set switch word can be loaded into any register. Any register can be copied to a latched LED output. A halt instruction freezes the processor until the next synchronous reset. Every instruction is one byte, written MSB to LSB as a 2-bit class `op[7:6]`, a 2-bit selector `cc[5:4]`, a 2-bit source register `src[3:2]` and a 2-bit destination register `dst[1:0]`. In that layout, register operations read `dst` and `src` and write `dst`.

Top module: `tiny_cpu`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the program counter, all four registers, both flags and `led_o`, and leaves the halted state. With `rst` held, `pc_o`=0, `led_o`=0 and `halted_o`=0.
- R2: Each instruction uses one fetch cycle and one execute cycle. `pc_o` does not change on the fetch edge. On the execute edge it becomes pc+1 modulo 16, so 15 wraps to 0, unless a branch is taken or a halt runs.
- R3: Class `op`=00 selects by `cc`: 00 add (dst=dst+src), 01 subtract (dst=dst-src), 10 move (dst=src), 11 clear (dst=0).
- R4: Class `op`=01 selects by `cc`: 00 increment (dst=dst+1, `src` ignored), 01 multiply (dst = low 8 bits of dst*src), 10 divide (dst = quotient dst/src), 11 AND (dst=dst&src).
- R5: A divide by a zero source writes 8'hFF to `dst` and sets the carry flag. The zero flag is left unchanged.
- R6: Add, subtract and increment set Z when the 8-bit result is zero. They set C to the carry out; for subtract, C is the borrow, so C=1 when dst<src. Move, clear, multiply, AND and a nonzero divide leave both flags unchanged.
- R7: Class `op`=11 with `cc`≠00 is a branch to the target in bits [3:0]. Code 01 is taken when Z=1, code 10 when C=1, and code 11 always. A branch that is not taken continues at pc+1.
- R8: Word 1100_L_H_dd with H (bit 2)=1 halts. `halted_o` rises, `pc_o` stays at the halt's address, and the state holds until reset.
- R9: With H=0, L (bit 3)=1 loads `sw_in` into register `dd`, and L=0 copies register `dd` to `led_o`. `led_o` changes at no other time except reset.
- R10: Class `op`=10 is a no-op. No register, flag or LED changes, and the program counter advances by one.
- R11: When `imem_we` is high at a clock edge, `imem_wdata` is stored at `imem_waddr`. Later fetches from that address return it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_we | input | 1 | Instruction memory write enable |
| imem_waddr | input | 4 | Instruction memory write address |
| imem_wdata | input | 8 | Instruction word to store |
| sw_in | input | 8 | Switch word read by the load instruction |
| led_o | output | 8 | Latched LED output |
| pc_o | output | 4 | Current program counter |
| halted_o | output | 1 | High while the processor is halted |

## Verification
Counting from the edge that first samples `rst` low, instruction k (starting at 1) is captured on edge 2k-1. Its register, flag, LED and program-counter results appear right after edge 2k. A program of n executed instructions ending in a halt shows `halted_o` after edge 2n. The bench counts edges exactly and samples at the falling edge after the edge where each result is due. The switch word is changed only between the execute edges of the two load instructions. The program-counter checks use the same count, so they also catch a fetch edge that moves the counter.

// File: rtl/tcpu_pkg.sv
package tcpu_pkg;
    localparam int INSTR_W    = 8;
    localparam int PC_W       = 4;
    localparam int IMEM_DEPTH = 1 << PC_W;

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_EXEC  = 2'd1,
        ST_HALT  = 2'd2
    } cpu_state_e;

    typedef enum logic [3:0] {
        FN_NOP, FN_ADD, FN_SUB, FN_MOV, FN_CLR,
        FN_INC, FN_MUL, FN_DIV, FN_AND
    } alu_fn_e;

    typedef struct packed {
        logic [1:0] op;
        logic [1:0] cc;
        logic [1:0] src;
        logic [1:0] dst;
    } instr_t;

    localparam logic [1:0] OP_REG  = 2'b00;
    localparam logic [1:0] OP_EXT  = 2'b01;
    localparam logic [1:0] OP_NONE = 2'b10;
    localparam logic [1:0] OP_CTL  = 2'b11;
endpackage

// File: rtl/tcpu_imem.sv
module tcpu_imem
    import tcpu_pkg::*;
#(
    parameter int WORD_W = INSTR_W,
    parameter int DEPTH  = IMEM_DEPTH,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem_q [DEPTH];
    logic [WORD_W-1:0] mem_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = (we && waddr == AW'(i)) ? wdata : mem_q[i];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_q[i] <= mem_d[i];
        end
    end

    assign rdata = mem_q[raddr];

    // R11: a written word is present at its address on the next cycle
    a_r11_write_lands: assert property (@(posedge clk) disable iff (rst)
        we |=> mem_q[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/tcpu_regfile.sv
module tcpu_regfile #(
    parameter int DATA_W = 8,
    parameter int NREG   = 4,
    localparam int SEL_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SEL_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SEL_W-1:0]  raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [SEL_W-1:0]  raddr_b,
    output logic [DATA_W-1:0] rdata_b
);
    logic [DATA_W-1:0] reg_q [NREG];
    logic [DATA_W-1:0] reg_d [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_comb begin
            reg_d[g] = (we && waddr == SEL_W'(g)) ? wdata : reg_q[g];
        end

        always_ff @(posedge clk) begin
            if (rst) reg_q[g] <= '0;
            else     reg_q[g] <= reg_d[g];
        end
    end

    assign rdata_a = reg_q[raddr_a];
    assign rdata_b = reg_q[raddr_b];
endmodule

// File: rtl/tcpu_alu.sv
module tcpu_alu
    import tcpu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_fn_e           fn,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res,
    output logic              res_we,
    output logic              z_we,
    output logic              c_we,
    output logic              z,
    output logic              c
);
    logic [DATA_W:0]     wide;
    logic [2*DATA_W-1:0] prod;

    always_comb begin
        wide   = '0;
        prod   = {{DATA_W{1'b0}}, a} * {{DATA_W{1'b0}}, b};
        res    = '0;
        res_we = 1'b0;
        z_we   = 1'b0;
        c_we   = 1'b0;
        c      = 1'b0;
        unique case (fn)
            FN_ADD: begin
                wide   = {1'b0, a} + {1'b0, b};
                res    = wide[DATA_W-1:0];
                c      = wide[DATA_W];
                res_we = 1'b1; z_we = 1'b1; c_we = 1'b1;
            end
            FN_SUB: begin
                wide   = {1'b0, a} - {1'b0, b};
                res    = wide[DATA_W-1:0];
                c      = wide[DATA_W];
                res_we = 1'b1; z_we = 1'b1; c_we = 1'b1;
            end
            FN_INC: begin
                wide   = {1'b0, a} + {{DATA_W{1'b0}}, 1'b1};
                res    = wide[DATA_W-1:0];
                c      = wide[DATA_W];
                res_we = 1'b1; z_we = 1'b1; c_we = 1'b1;
            end
            FN_MOV: begin res = b;                 res_we = 1'b1; end
            FN_CLR: begin res = '0;                res_we = 1'b1; end
            FN_MUL: begin res = prod[DATA_W-1:0];  res_we = 1'b1; end
            FN_AND: begin res = a & b;             res_we = 1'b1; end
            FN_DIV: begin
                res_we = 1'b1;
                if (b == '0) begin
                    res  = '1;
                    c    = 1'b1;
                    c_we = 1'b1;
                end else begin
                    res = a / b;
                end
            end
            default: ;
        endcase
        z = (res == '0);
    end
endmodule

// File: rtl/tiny_cpu.sv
module tiny_cpu
    import tcpu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NREG   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              imem_we,
    input  logic [PC_W-1:0]   imem_waddr,
    input  logic [INSTR_W-1:0] imem_wdata,
    input  logic [DATA_W-1:0] sw_in,
    output logic [DATA_W-1:0] led_o,
    output logic [PC_W-1:0]   pc_o,
    output logic              halted_o
);
    localparam int SEL_W = $clog2(NREG);

    typedef struct packed {
        cpu_state_e        st;
        logic [PC_W-1:0]   pc;
        instr_t            ir;
        logic              zf;
        logic              cf;
        logic [DATA_W-1:0] led;
    } cpu_t;

    cpu_t cpu_d, cpu_q;

    logic [INSTR_W-1:0] fetch_word;
    logic [DATA_W-1:0]  rd_a, rd_b;
    logic               is_sys, is_br, is_alu, br_taken, in_exec;
    logic               sys_halt, sys_load;
    alu_fn_e            fn;
    logic [DATA_W-1:0]  alu_res;
    logic               alu_we, alu_z_we, alu_c_we, alu_z, alu_c;
    logic               rf_we;
    logic [DATA_W-1:0]  rf_wdata;

    tcpu_imem #(.WORD_W(INSTR_W), .DEPTH(IMEM_DEPTH)) u_imem (
        .clk(clk), .rst(rst), .we(imem_we), .waddr(imem_waddr),
        .wdata(imem_wdata), .raddr(cpu_q.pc), .rdata(fetch_word)
    );

    // decode of the held instruction
    always_comb begin
        in_exec  = (cpu_q.st == ST_EXEC);
        is_sys   = (cpu_q.ir.op == OP_CTL) && (cpu_q.ir.cc == 2'b00);
        is_br    = (cpu_q.ir.op == OP_CTL) && (cpu_q.ir.cc != 2'b00);
        is_alu   = (cpu_q.ir.op == OP_REG) || (cpu_q.ir.op == OP_EXT);
        sys_load = cpu_q.ir.src[1];
        sys_halt = cpu_q.ir.src[0];
        unique case (cpu_q.ir.cc)
            2'b01:   br_taken = cpu_q.zf;
            2'b10:   br_taken = cpu_q.cf;
            default: br_taken = 1'b1;
        endcase
        fn = FN_NOP;
        if (cpu_q.ir.op == OP_REG) begin
            unique case (cpu_q.ir.cc)
                2'b00: fn = FN_ADD;
                2'b01: fn = FN_SUB;
                2'b10: fn = FN_MOV;
                default: fn = FN_CLR;
            endcase
        end else if (cpu_q.ir.op == OP_EXT) begin
            unique case (cpu_q.ir.cc)
                2'b00: fn = FN_INC;
                2'b01: fn = FN_MUL;
                2'b10: fn = FN_DIV;
                default: fn = FN_AND;
            endcase
        end
    end

    tcpu_alu #(.DATA_W(DATA_W)) u_alu (
        .fn(fn), .a(rd_a), .b(rd_b), .res(alu_res), .res_we(alu_we),
        .z_we(alu_z_we), .c_we(alu_c_we), .z(alu_z), .c(alu_c)
    );

    always_comb begin
        rf_we    = in_exec && ((is_alu && alu_we) || (is_sys && !sys_halt && sys_load));
        rf_wdata = is_sys ? sw_in : alu_res;
    end

    tcpu_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
        .clk(clk), .rst(rst), .we(rf_we), .waddr(SEL_W'(cpu_q.ir.dst)),
        .wdata(rf_wdata), .raddr_a(SEL_W'(cpu_q.ir.dst)), .rdata_a(rd_a),
        .raddr_b(SEL_W'(cpu_q.ir.src)), .rdata_b(rd_b)
    );

    // next-state computation
    always_comb begin
        cpu_d = cpu_q;
        unique case (cpu_q.st)
            ST_FETCH: begin
                cpu_d.ir = instr_t'(fetch_word);
                cpu_d.st = ST_EXEC;
            end
            ST_EXEC: begin
                cpu_d.st = ST_FETCH;
                cpu_d.pc = cpu_q.pc + PC_W'(1);
                if (is_sys) begin
                    if (sys_halt) begin
                        cpu_d.st = ST_HALT;
                        cpu_d.pc = cpu_q.pc;
                    end else if (!sys_load) begin
                        cpu_d.led = rd_a;
                    end
                end else if (is_br) begin
                    if (br_taken) cpu_d.pc = {cpu_q.ir.src, cpu_q.ir.dst};
                end else if (is_alu) begin
                    if (alu_z_we) cpu_d.zf = alu_z;
                    if (alu_c_we) cpu_d.cf = alu_c;
                end
            end
            ST_HALT: ;
            default: cpu_d.st = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_q.st  <= ST_FETCH;
            cpu_q.pc  <= '0;
            cpu_q.ir  <= '0;
            cpu_q.zf  <= 1'b0;
            cpu_q.cf  <= 1'b0;
            cpu_q.led <= '0;
        end else begin
            cpu_q <= cpu_d;
        end
    end

    assign led_o    = cpu_q.led;
    assign pc_o     = cpu_q.pc;
    assign halted_o = (cpu_q.st == ST_HALT);

    // R2: the fetch edge leaves the program counter alone
    a_r2_fetch_pc_hold: assert property (@(posedge clk) disable iff (rst)
        (cpu_q.st == ST_FETCH) |=> $stable(pc_o));

    // R8: halt persists and freezes the program counter
    a_r8_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        halted_o |=> (halted_o && $stable(pc_o)));

    // R9: the LED latch does not move while halted
    a_r9_led_frozen: assert property (@(posedge clk) disable iff (rst)
        halted_o |=> $stable(led_o));

    // R5: divide by zero leaves carry set
    a_r5_div0_carry: assert property (@(posedge clk) disable iff (rst)
        (in_exec && cpu_q.ir.op == OP_EXT && cpu_q.ir.cc == 2'b10 && rd_b == '0)
        |=> cpu_q.cf);

    // R10: the reserved class touches neither flags nor LED
    a_r10_nop_quiet: assert property (@(posedge clk) disable iff (rst)
        (in_exec && cpu_q.ir.op == OP_NONE)
        |=> ($stable(cpu_q.zf) && $stable(cpu_q.cf) && $stable(led_o)));

    // R7: an unconditional branch lands on its target
    a_r7_jump_lands: assert property (@(posedge clk) disable iff (rst)
        (in_exec && cpu_q.ir.op == OP_CTL && cpu_q.ir.cc == 2'b11)
        |=> pc_o == $past({cpu_q.ir.src, cpu_q.ir.dst}));
endmodule

// File: tb/tiny_cpu_tb.sv
module tiny_cpu_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       imem_we = 1'b0;
    logic [3:0] imem_waddr = '0;
    logic [7:0] imem_wdata = '0;
    logic [7:0] sw_in = '0;
    logic [7:0] led_o;
    logic [3:0] pc_o;
    logic       halted_o;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #5 clk = ~clk;

    tiny_cpu u_dut (
        .clk(clk), .rst(rst), .imem_we(imem_we), .imem_waddr(imem_waddr),
        .imem_wdata(imem_wdata), .sw_in(sw_in), .led_o(led_o),
        .pc_o(pc_o), .halted_o(halted_o)
    );

    typedef struct packed {
        logic [7:0] op;
        logic [7:0] a;
        logic [7:0] b;
        logic [7:0] br;
        logic [7:0] led;
        logic [3:0] pc;
        logic [3:0] req;
    } vec_t;

    // program: IN r0, IN r1, <op src=r1 dst=r0>, OUT r0, <branch to 6>, HALT, HALT
    // branch 0xD6 = on zero, 0xE6 = on carry; taken -> halt at 6, else at 5
    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{8'h04, 8'h12, 8'h34, 8'hE6, 8'h46, 4'd5, 4'd3},
        '{8'h04, 8'hF0, 8'h20, 8'hE6, 8'h10, 4'd6, 4'd6},
        '{8'h04, 8'h80, 8'h80, 8'hD6, 8'h00, 4'd6, 4'd6},
        '{8'h14, 8'h50, 8'h20, 8'hE6, 8'h30, 4'd5, 4'd3},
        '{8'h14, 8'h20, 8'h50, 8'hE6, 8'hD0, 4'd6, 4'd6},
        '{8'h14, 8'h33, 8'h33, 8'hD6, 8'h00, 4'd6, 4'd6},
        '{8'h24, 8'h11, 8'hA5, 8'hD6, 8'hA5, 4'd5, 4'd3},
        '{8'h34, 8'h11, 8'h22, 8'hD6, 8'h00, 4'd5, 4'd6},
        '{8'h44, 8'hFF, 8'h00, 8'hE6, 8'h00, 4'd6, 4'd6},
        '{8'h44, 8'h41, 8'h09, 8'hD6, 8'h42, 4'd5, 4'd4},
        '{8'h54, 8'h12, 8'h10, 8'hE6, 8'h20, 4'd5, 4'd4},
        '{8'h64, 8'hC8, 8'h07, 8'hE6, 8'h1C, 4'd5, 4'd4},
        '{8'h64, 8'h55, 8'h00, 8'hE6, 8'hFF, 4'd6, 4'd5},
        '{8'h74, 8'hF0, 8'h3C, 8'hD6, 8'h30, 4'd5, 4'd4},
        '{8'hB4, 8'h77, 8'h12, 8'hD6, 8'h77, 4'd5, 4'd10}
    };

    function automatic string tag(input logic [3:0] r);
        case (r)
            4'd3:  return "R3";
            4'd4:  return "R4";
            4'd5:  return "R5";
            4'd6:  return "R6";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string what, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", what, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        imem_we = 1'b1; imem_waddr = a; imem_wdata = d;
        @(negedge clk);
        imem_we = 1'b0;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL R2 watchdog expired: got %0d expected below 100000", cyc);
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        // table walk
        for (int i = 0; i < NV; i++) begin
            rst = 1'b1;
            wr(4'd0, 8'hC8); wr(4'd1, 8'hC9); wr(4'd2, VECS[i].op);
            wr(4'd3, 8'hC0); wr(4'd4, VECS[i].br); wr(4'd5, 8'hC4);
            wr(4'd6, 8'hC4);
            sw_in = VECS[i].a;
            rst = 1'b0;
            cycles(2);
            sw_in = VECS[i].b;
            cycles(10);
            check({tag(VECS[i].req), " result on LED"}, led_o, VECS[i].led);
            check({tag(VECS[i].req), " flag branch pc"}, {4'h0, pc_o}, {4'h0, VECS[i].pc});
            check("R11 loaded program reached halt", {7'h0, halted_o}, 8'h01);
        end

        // R1: reset state while held
        rst = 1'b1;
        cycles(1);
        check("R1 pc in reset", {4'h0, pc_o}, 8'h00);
        check("R1 led in reset", led_o, 8'h00);
        check("R1 halted in reset", {7'h0, halted_o}, 8'h00);

        // R1: registers cleared by reset (r3 dirtied first)
        wr(4'd0, 8'hCB); wr(4'd1, 8'hC4);
        sw_in = 8'h5A;
        rst = 1'b0;
        cycles(4);
        check("R8 halt after load", {7'h0, halted_o}, 8'h01);
        rst = 1'b1;
        wr(4'd0, 8'h43); wr(4'd1, 8'hC3); wr(4'd2, 8'hC4);
        rst = 1'b0;
        cycles(6);
        check("R1 register cleared then incremented", led_o, 8'h01);
        check("R9 output copies register", led_o, 8'h01);

        // R8/R9: halted state ignores time and switches
        sw_in = 8'hEE;
        cycles(20);
        check("R8 stays halted", {7'h0, halted_o}, 8'h01);
        check("R8 pc frozen at halt", {4'h0, pc_o}, 8'h02);
        check("R9 led unchanged while halted", led_o, 8'h01);

        // R1: reset leaves halt
        rst = 1'b1;
        cycles(1);
        check("R1 reset exits halt", {7'h0, halted_o}, 8'h00);

        // R2/R7: fetch timing, not-taken, jump, wrap, taken-on-zero
        wr(4'd0, 8'hD5); wr(4'd1, 8'h10); wr(4'd2, 8'hFF);
        wr(4'd15, 8'h80); wr(4'd5, 8'hC4);
        rst = 1'b0;
        cycles(1);
        check("R2 pc holds on fetch edge", {4'h0, pc_o}, 8'h00);
        cycles(1);
        check("R7 not-taken branch steps", {4'h0, pc_o}, 8'h01);
        cycles(4);
        check("R7 unconditional jump target", {4'h0, pc_o}, 8'h0F);
        cycles(1);
        check("R2 pc holds during fetch", {4'h0, pc_o}, 8'h0F);
        cycles(1);
        check("R2 pc wraps 15 to 0", {4'h0, pc_o}, 8'h00);
        cycles(4);
        check("R7 zero branch taken", {4'h0, pc_o}, 8'h05);
        check("R8 halt reached", {7'h0, halted_o}, 8'h01);

        finish_run();
    end
endmodule